// File: doc/BRIEF.md
# Read-Modify-Write Bus Lock Generator

This block produces an active-low lock output for shared-bus arbitration in a multi-master system. When the processor runs a memory read-modify-write instruction (a shift, rotate, increment, decrement, or a bit test-and-clear or test-and-set on memory), the lock is driven low for the closing cycles of that instruction. An external arbiter sees the low level and holds off granting the next bus cycle to any other master. The read and the write-back therefore stay together.

The sequencer pulses an instruction-start strobe in the first cycle of every instruction. With the strobe it supplies three things: a read-modify-write class bit, the operand-width flag, and the instruction's total length in cycles. The width flag sets the size of the lock window. An 8-bit operand gets three cycles and a 16-bit operand gets five. The flag is captured at the strobe and held for the rest of the instruction. The output comes straight from a register, so it is clean for off-block routing.

Top module: `rmw_bus_lock`

## Requirements
- R1: `lock_n` is 1 in every cycle that follows a clock edge with `rst` high. It stays 1 until a read-modify-write instruction opens a window.
- R2: An instruction started with `instr_rmw` = 0 keeps `lock_n` at 1 from its cycle 1 to its end.
- R3: Let an instruction be started with `width_narrow` = 1 and `instr_rmw` = 1, with length L cycles (cycle 0 is the strobe cycle). Then `lock_n` is 0 exactly in cycles L-3 through L-1.
- R4: Let an instruction be started with `width_narrow` = 0 and `instr_rmw` = 1, with length L cycles. Then `lock_n` is 0 exactly in cycles L-5 through L-1.
- R5: `lock_n` returns to 1 on the clock edge that ends cycle L-1. It stays 1 until a later start opens a new window.
- R6: `width_narrow` is sampled only in the strobe cycle. Changes to it during cycles 1 to L-1 do not alter the window.
- R7: If the window would begin before cycle 1, it is clipped to begin at cycle 1. A length of 0 is treated as 1, and an instruction of length 1 produces no lock.
- R8: A new start strobe that arrives before the current instruction ends abandons the old instruction. Timing then follows the new instruction alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_start | input | 1 | High in the first cycle of each instruction |
| instr_rmw | input | 1 | Read-modify-write memory class; sampled with `instr_start` |
| width_narrow | input | 1 | 1 = 8-bit operand, 0 = 16-bit; sampled with `instr_start` |
| instr_len | input | CNT_W | Total instruction length in cycles; sampled with `instr_start` |
| lock_n | output | 1 | Active-low bus lock, registered |

## Verification
The bench checks short instructions whose window would begin before cycle 1 or at it. A design that does not clip the window would either lock in the strobe cycle or drop the lock entirely. It flips the width flag in the middle of an instruction. A design that reads the flag live would stretch a 3-cycle window to 5 cycles, or shrink a 5-cycle window to 3. The bench also aborts instructions with a new strobe while a window is open, and applies reset inside a window. A design that lets the old countdown run on would hold the lock past the new instruction's bounds.

// File: rtl/rmw_lock_pkg.sv
package rmw_lock_pkg;

  typedef struct packed {
    logic rmw;
    logic narrow;
  } instr_attr_t;

  localparam instr_attr_t ATTR_IDLE = '{rmw: 1'b0, narrow: 1'b0};

endpackage

// File: rtl/rmw_span_sel.sv
module rmw_span_sel #(
  parameter int NARROW_SPAN = 3,
  parameter int WIDE_SPAN   = 5,
  parameter int SPAN_W      = 3
) (
  input  logic              narrow,
  output logic [SPAN_W-1:0] span
);

  localparam logic [SPAN_W-1:0] NSPAN = SPAN_W'(NARROW_SPAN);
  localparam logic [SPAN_W-1:0] WSPAN = SPAN_W'(WIDE_SPAN);

  generate
    if (NARROW_SPAN == WIDE_SPAN) begin : g_fixed
      assign span = NSPAN;
    end else begin : g_sel
      assign span = narrow ? NSPAN : WSPAN;
    end
  endgenerate

endmodule

// File: rtl/rmw_cycle_track.sv
module rmw_cycle_track #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cur_rem
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] start_rem;

  // cycles left after the strobe cycle; length 0 is treated as 1
  assign start_rem = (len == '0) ? '0 : len - ONE;
  assign cur_rem   = start ? start_rem : rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (start) begin
      rem_q <= (len >= TWO) ? len - TWO : '0;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - ONE;
    end
  end

endmodule

// File: rtl/rmw_bus_lock.sv
module rmw_bus_lock
  import rmw_lock_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int NARROW_SPAN = 3,
  parameter int WIDE_SPAN   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_start,
  input  logic             instr_rmw,
  input  logic             width_narrow,
  input  logic [CNT_W-1:0] instr_len,
  output logic             lock_n
);

  localparam int MAX_SPAN = (WIDE_SPAN > NARROW_SPAN) ? WIDE_SPAN : NARROW_SPAN;
  localparam int SPAN_W   = $clog2(MAX_SPAN + 1);

  instr_attr_t      attr_q;
  instr_attr_t      attr_cur;
  logic [CNT_W-1:0] cur_rem;
  logic [SPAN_W-1:0] span;
  logic             lock_d;
  logic             lock_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q <= ATTR_IDLE;
    end else if (instr_start) begin
      attr_q <= '{rmw: instr_rmw, narrow: width_narrow};
    end
  end

  assign attr_cur = instr_start ? instr_attr_t'{rmw: instr_rmw, narrow: width_narrow} : attr_q;

  rmw_cycle_track #(.CNT_W(CNT_W)) u_track (
    .clk    (clk),
    .rst    (rst),
    .start  (instr_start),
    .len    (instr_len),
    .cur_rem(cur_rem)
  );

  rmw_span_sel #(
    .NARROW_SPAN(NARROW_SPAN),
    .WIDE_SPAN  (WIDE_SPAN),
    .SPAN_W     (SPAN_W)
  ) u_span (
    .narrow(attr_cur.narrow),
    .span  (span)
  );

  // next cycle is locked when it is one of the last span cycles
  assign lock_d = attr_cur.rmw && (cur_rem != '0) && (cur_rem <= CNT_W'(span));

  always_ff @(posedge clk) begin
    if (rst) lock_n_q <= 1'b1;
    else     lock_n_q <= ~lock_d;
  end

  assign lock_n = lock_n_q;

endmodule

// File: rtl/rmw_bus_lock_chk.sv
module rmw_bus_lock_chk #(
  parameter int NARROW_SPAN = 3,
  parameter int WIDE_SPAN   = 5
) (
  input logic clk,
  input logic rst,
  input logic instr_start,
  input logic instr_rmw,
  input logic width_narrow,
  input logic lock_n
);

  logic       rmw_seen;
  logic       nar_seen;
  logic [7:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rmw_seen <= 1'b0;
      nar_seen <= 1'b0;
    end else if (instr_start) begin
      rmw_seen <= instr_rmw;
      nar_seen <= width_narrow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || instr_start || lock_n) run <= '0;
    else if (run != 8'hff)            run <= run + 8'd1;
  end

  AST_RESET_RELEASE: assert property (@(posedge clk) rst |=> lock_n); // R1

  AST_NONRMW_HIGH: assert property (@(posedge clk) disable iff (rst)
    instr_start && !instr_rmw |=> lock_n); // R2

  AST_LOCK_ONLY_RMW: assert property (@(posedge clk) disable iff (rst)
    !lock_n |-> rmw_seen); // R2

  AST_NARROW_SPAN: assert property (@(posedge clk) disable iff (rst)
    !lock_n && nar_seen |-> run < 8'(NARROW_SPAN)); // R3

  AST_WIDE_SPAN: assert property (@(posedge clk) disable iff (rst)
    !lock_n |-> run < 8'(WIDE_SPAN)); // R4

endmodule

bind rmw_bus_lock rmw_bus_lock_chk #(
  .NARROW_SPAN(NARROW_SPAN),
  .WIDE_SPAN  (WIDE_SPAN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_start (instr_start),
  .instr_rmw   (instr_rmw),
  .width_narrow(width_narrow),
  .lock_n      (lock_n)
);

// File: tb/rmw_bus_lock_bench.sv
`timescale 1ns/1ps
module rmw_bus_lock_bench;

  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             instr_start = 1'b0;
  logic             instr_rmw = 1'b0;
  logic             width_narrow = 1'b0;
  logic [CNT_W-1:0] instr_len = '0;
  logic             lock_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  bit    m_live = 0;
  int    m_len = 1, m_k = 0;
  bit    m_r = 0, m_n = 0, m_abort = 0, m_wchg = 0;
  bit    exp_n = 1;
  string exp_tag = "R1";

  always #2.5 clk = ~clk;

  rmw_bus_lock #(.CNT_W(CNT_W)) u_rmw_bus_lock (
    .clk(clk), .rst(rst), .instr_start(instr_start), .instr_rmw(instr_rmw),
    .width_narrow(width_narrow), .instr_len(instr_len), .lock_n(lock_n)
  );

  function automatic bit want_low(int j, int len, bit r, bit nar);
    int span = nar ? 3 : 5;
    return r && (j >= 1) && (j <= len - 1) && (j >= len - span);
  endfunction

  function automatic string pick_tag(int j);
    int span = m_n ? 3 : 5;
    if (!m_live)        return "R1";
    if (j > m_len - 1)  return "R5";
    if (m_abort)        return "R8";
    if (m_wchg)         return "R6";
    if (m_len <= span)  return "R7";
    if (!m_r)           return "R2";
    return m_n ? "R3" : "R4";
  endfunction

  task automatic cyc(input bit rs, input bit st, input bit r, input bit nw, input int len);
    @(negedge clk);
    n_chk++;
    if (lock_n !== exp_n) begin
      n_bad++;
      $display("FAIL %s: lock_n actual %b expected %b at %0t", exp_tag, lock_n, exp_n, $time);
    end
    rst = rs; instr_start = st; instr_rmw = r; width_narrow = nw;
    instr_len = CNT_W'(len);
    if (rs) begin
      m_live = 0;
    end else if (st) begin
      m_abort = m_live && (m_k < m_len - 1);
      m_len = (len < 1) ? 1 : len;
      m_k = 0; m_r = r; m_n = nw; m_live = 1; m_wchg = 0;
    end else if (m_live) begin
      m_k++;
      if (m_k <= m_len - 1 && nw != m_n) m_wchg = 1;
    end
    if (!m_live) begin
      exp_n = 1; exp_tag = "R1";
    end else begin
      exp_n = !want_low(m_k + 1, m_len, m_r, m_n);
      exp_tag = pick_tag(m_k + 1);
    end
  endtask

  // one instruction followed by idle cycles; flip_w toggles width mid-way
  task automatic run_instr(input bit r, input bit nw, input int len, input int gap, input bit flip_w);
    int tot = (len < 1 ? 1 : len) + gap;
    cyc(0, 1, r, nw, len);
    for (int i = 1; i < tot; i++) cyc(0, 0, 0, flip_w ? ~nw : nw, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(posedge clk); @(posedge clk);
    // reset state, R1
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // directed: R3 narrow, R4 wide
    run_instr(1, 1, 8, 3, 0);
    run_instr(1, 0, 10, 3, 0);
    run_instr(1, 0, 6, 2, 0);   // window starts exactly at cycle 1
    // R2 non-rmw
    run_instr(0, 1, 9, 2, 0);
    // R7 clipping and tiny lengths
    run_instr(1, 1, 3, 2, 0);
    run_instr(1, 0, 4, 2, 0);
    run_instr(1, 1, 1, 2, 0);
    run_instr(1, 0, 0, 2, 0);
    // R6 width change ignored
    run_instr(1, 1, 9, 2, 1);
    run_instr(1, 0, 9, 2, 1);
    // R8 abort inside a window, back-to-back starts, R5 release
    cyc(0, 1, 1, 0, 12);
    for (int i = 1; i < 9; i++) cyc(0, 0, 0, 0, 0);
    run_instr(1, 1, 6, 0, 0);
    run_instr(0, 0, 7, 0, 0);
    run_instr(1, 0, 7, 3, 0);
    // reset inside a window, R1
    cyc(0, 1, 1, 0, 10);
    for (int i = 1; i < 7; i++) cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // constrained random
    for (int n = 0; n < 500; n++) begin
      bit r   = ($urandom % 4) != 0;
      bit nw  = $urandom % 2;
      int len = $urandom % 14;
      int gap = $urandom % 3;
      bit fl  = ($urandom % 4) == 0;
      if (($urandom % 6) == 0) begin
        int cut = 1 + $urandom % 8;
        cyc(0, 1, r, nw, len);
        for (int i = 1; i < cut; i++) cyc(0, 0, 0, nw, 0);
      end else begin
        run_instr(r, nw, len, gap, fl);
      end
    end
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule